// File: doc/BRIEF.md
# Circular-Core Instruction Execute Unit

This unit performs the execute step of a small two-operand virtual machine whose memory is a ring of `M` cells. Each cell holds an opcode, an A-mode, an A-field, a B-mode and a B-field. An upstream operand stage has already resolved both operand addresses and fetched both target cells. It hands the unit the opcode, the two modes, the instruction's own A-field, the program counter, the two resolved addresses and the two cells. One cycle later the unit returns a single result pulse. The pulse carries the next program counter for the running task, an optional cell write request, and kill or split requests for the task scheduler.

The immediate mode changes the semantics. With an immediate operand, moves, compares and arithmetic work on single fields. Without one, they work on whole cells, or on both fields pairwise. Every address and field is relative and wraps modulo `M`. A data cell ends the running task rather than trapping. Any decrement done by the operand stage is already in memory at that point, so the unit itself issues no write for it.

Top module: `exu_core`

## Requirements
- R1: While `rst_ni` is low, `done_o`, `kill_o`, `split_o`, `wr_en_o` and `in_ready_o` are low. `in_ready_o` goes high on the first clock edge after reset is released and stays high.
- R2: An instruction is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both high. `done_o` is high for exactly the cycle after each accept and low otherwise. `kill_o`, `split_o` and `wr_en_o` are low whenever `done_o` is low.
- R3: Opcode 0 (data) and the unused opcodes 11 to 15 give `kill_o`=1, `wr_en_o`=0, `split_o`=0 and `next_pc_o` equal to the PC.
- R4: Opcode 1 (move) writes to the B address, and the PC advances by 1. Mode 0 is immediate; modes 1 to 3 are not. A cell is packed as {op[3:0], a_mode[1:0], a_field[AW-1:0], b_mode[1:0], b_field[AW-1:0]}, with the B-field in the low bits.
  - If either mode is immediate, the written cell is the B cell with its B-field replaced by the A value. The A value is the instruction A-field when the A-mode is immediate, and the A cell's B-field otherwise.
  - If neither mode is immediate, the written cell is the A cell.
- R5: Opcode 2 (add) and opcode 3 (subtract) write to the B address, and the PC advances by 1.
  - With an immediate A-mode, the B cell is written with its B-field changed to B-field plus (or minus) the instruction A-field.
  - With a non-immediate A-mode, the B cell's A-field and B-field are each combined with the A cell's A-field and B-field respectively.
- R6: Opcode 5 (jump if zero) and opcode 6 (jump if nonzero) go to the jump target when the B cell's B-field is zero (for 5) or nonzero (for 6). Otherwise the PC advances by 1. The jump target is the A address, or the PC itself when the A-mode is immediate. Neither opcode writes.
- R7: Opcode 7 (decrement and jump) writes the B cell to the B address with its B-field decremented modulo `M`. It goes to the jump target only if the decremented value is nonzero; otherwise the PC advances by 1.
- R8: Opcode 8 (compare) advances the PC by 2 when the operands are equal and by 1 otherwise.
  - If either mode is immediate, the A value is compared with the B cell's B-field.
  - If neither mode is immediate, all fields of the two cells are compared.
  - Compare does not write.
- R9: Opcode 10 (skip if less) advances the PC by 2 when the A value is less than the B cell's B-field and by 1 otherwise. It does not write.
- R10: Opcode 4 (jump) sets `next_pc_o` to the jump target. Opcode 9 (split) raises `split_o` with `split_addr_o` equal to the jump target, and advances the PC by 1. Neither opcode writes.
- R11: All inputs are reduced modulo `M` before use. Every field, address and next-PC output is in 0 to `M`-1, and PC+1 and PC+2 wrap past `M`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Unit can accept |
| op_i | input | 4 | Opcode |
| a_mode_i | input | 2 | A operand mode (0 immediate) |
| a_field_i | input | AW | Instruction A-field |
| b_mode_i | input | 2 | B operand mode (0 immediate) |
| pc_i | input | AW | Current program counter |
| a_addr_i | input | AW | Resolved A address |
| b_addr_i | input | AW | Resolved B address |
| a_cell_i | input | 2*AW+8 | Cell at the A address |
| b_cell_i | input | 2*AW+8 | Cell at the B address |
| done_o | output | 1 | Result pulse |
| next_pc_o | output | AW | Next PC of the running task |
| kill_o | output | 1 | Remove the running task |
| split_o | output | 1 | Queue a new task |
| split_addr_o | output | AW | Start address of the new task |
| wr_en_o | output | 1 | Cell write request |
| wr_addr_o | output | AW | Write address |
| wr_cell_o | output | 2*AW+8 | Cell to write |

## Verification
Directed cases come first. Each one separates immediate from whole-cell behaviour for move, add, compare and skip. Each one also puts a field or the PC right at the wrap point, for example a decrement from 0 to `M`-1 that still branches, and a decrement from 1 to 0 that does not. After these come several hundred random instructions over all sixteen opcode codes and all mode pairs. Field values above `M`-1 exercise input normalisation. Some of the random compares copy the A cell into the B cell, so that the equal outcome and the unequal outcome are both seen. Idle cycles between accepts show that the result pulse and the side outputs stay quiet when nothing is accepted.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int OPW = 4;
  localparam int MDW = 2;

  localparam logic [OPW-1:0] OP_DAT = 4'd0;
  localparam logic [OPW-1:0] OP_MOV = 4'd1;
  localparam logic [OPW-1:0] OP_ADD = 4'd2;
  localparam logic [OPW-1:0] OP_SUB = 4'd3;
  localparam logic [OPW-1:0] OP_JMP = 4'd4;
  localparam logic [OPW-1:0] OP_JMZ = 4'd5;
  localparam logic [OPW-1:0] OP_JMN = 4'd6;
  localparam logic [OPW-1:0] OP_DJN = 4'd7;
  localparam logic [OPW-1:0] OP_CMP = 4'd8;
  localparam logic [OPW-1:0] OP_SPL = 4'd9;
  localparam logic [OPW-1:0] OP_SLT = 4'd10;

  localparam logic [MDW-1:0] MODE_IMM = 2'd0;
endpackage

// File: rtl/exu_norm.sv
module exu_norm #(
  parameter int M  = 8000,
  parameter int AW = $clog2(M)
) (
  input  logic [AW-1:0] x_i,
  output logic [AW-1:0] y_o
);
  localparam logic [AW:0]   M_W = (AW+1)'(M);
  localparam logic [AW-1:0] M_L = AW'(M);

  // 2^AW < 2M, so a single conditional subtract is enough
  assign y_o = ({1'b0, x_i} >= M_W) ? (x_i - M_L) : x_i;

  always_comb begin
    AST_NORM_RANGE: assert ({1'b0, y_o} < M_W); // R11
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int M  = 8000,
  parameter int AW = $clog2(M),
  localparam int CW = OPW + 2*MDW + 2*AW
) (
  input  logic [OPW-1:0] op_i,
  input  logic           a_imm_i,
  input  logic           b_imm_i,
  input  logic [AW-1:0]  i_af_i,
  input  logic [CW-1:0]  a_cell_i,
  input  logic [CW-1:0]  b_cell_i,
  output logic           wr_en_o,
  output logic [CW-1:0]  wr_cell_o
);
  localparam logic [AW:0] M_W = (AW+1)'(M);
  localparam int BF_LO = 0;
  localparam int AF_LO = AW + MDW;

  function automatic logic [AW-1:0] add_m(input logic [AW-1:0] x, input logic [AW-1:0] y);
    logic [AW:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= M_W) s = s - M_W;
    return s[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] sub_m(input logic [AW-1:0] x, input logic [AW-1:0] y);
    logic [AW:0] s;
    s = {1'b0, x} + M_W - {1'b0, y};
    if (s >= M_W) s = s - M_W;
    return s[AW-1:0];
  endfunction

  logic [AW-1:0] a_af, a_bf, b_af, b_bf, a_val;
  logic          field_mode;

  assign a_af       = a_cell_i[AF_LO +: AW];
  assign a_bf       = a_cell_i[BF_LO +: AW];
  assign b_af       = b_cell_i[AF_LO +: AW];
  assign b_bf       = b_cell_i[BF_LO +: AW];
  assign a_val      = a_imm_i ? i_af_i : a_bf;
  assign field_mode = a_imm_i | b_imm_i;

  always_comb begin
    wr_en_o   = 1'b0;
    wr_cell_o = b_cell_i;
    unique case (op_i)
      OP_MOV: begin
        wr_en_o = 1'b1;
        if (field_mode) wr_cell_o[BF_LO +: AW] = a_val;
        else            wr_cell_o = a_cell_i;
      end
      OP_ADD: begin
        wr_en_o = 1'b1;
        if (a_imm_i) begin
          wr_cell_o[BF_LO +: AW] = add_m(b_bf, i_af_i);
        end else begin
          wr_cell_o[AF_LO +: AW] = add_m(b_af, a_af);
          wr_cell_o[BF_LO +: AW] = add_m(b_bf, a_bf);
        end
      end
      OP_SUB: begin
        wr_en_o = 1'b1;
        if (a_imm_i) begin
          wr_cell_o[BF_LO +: AW] = sub_m(b_bf, i_af_i);
        end else begin
          wr_cell_o[AF_LO +: AW] = sub_m(b_af, a_af);
          wr_cell_o[BF_LO +: AW] = sub_m(b_bf, a_bf);
        end
      end
      OP_DJN: begin
        wr_en_o = 1'b1;
        wr_cell_o[BF_LO +: AW] = sub_m(b_bf, AW'(1));
      end
      default: ;
    endcase
  end

  always_comb begin
    if (wr_en_o) begin
      AST_WR_FIELDS_RANGE: assert ({1'b0, wr_cell_o[AF_LO +: AW]} < M_W &&
                                   {1'b0, wr_cell_o[BF_LO +: AW]} < M_W); // R11
    end
  end
endmodule

// File: rtl/exu_flow.sv
module exu_flow
  import exu_pkg::*;
#(
  parameter int M  = 8000,
  parameter int AW = $clog2(M),
  localparam int CW = OPW + 2*MDW + 2*AW
) (
  input  logic [OPW-1:0] op_i,
  input  logic           a_imm_i,
  input  logic           b_imm_i,
  input  logic [AW-1:0]  i_af_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [AW-1:0]  a_addr_i,
  input  logic [CW-1:0]  a_cell_i,
  input  logic [CW-1:0]  b_cell_i,
  output logic [AW-1:0]  next_pc_o,
  output logic           kill_o,
  output logic           split_o,
  output logic [AW-1:0]  split_addr_o
);
  localparam logic [AW:0] M_W = (AW+1)'(M);

  function automatic logic [AW-1:0] adv_m(input logic [AW-1:0] x, input logic [AW-1:0] y);
    logic [AW:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= M_W) s = s - M_W;
    return s[AW-1:0];
  endfunction

  logic [AW-1:0] a_val, b_bf, tgt, pc1, pc2;
  logic          field_mode, equal, less;

  assign b_bf       = b_cell_i[AW-1:0];
  assign a_val      = a_imm_i ? i_af_i : a_cell_i[AW-1:0];
  assign field_mode = a_imm_i | b_imm_i;
  assign tgt        = a_imm_i ? pc_i : a_addr_i;
  assign pc1        = adv_m(pc_i, AW'(1));
  assign pc2        = adv_m(pc_i, AW'(2));
  assign equal      = field_mode ? (a_val == b_bf) : (a_cell_i == b_cell_i);
  assign less       = a_val < b_bf;

  always_comb begin
    next_pc_o    = pc1;
    kill_o       = 1'b0;
    split_o      = 1'b0;
    split_addr_o = tgt;
    unique case (op_i)
      OP_MOV, OP_ADD, OP_SUB: next_pc_o = pc1;
      OP_JMP: next_pc_o = tgt;
      OP_JMZ: next_pc_o = (b_bf == '0) ? tgt : pc1;
      OP_JMN: next_pc_o = (b_bf != '0) ? tgt : pc1;
      // decremented value is zero only when the old value was 1
      OP_DJN: next_pc_o = (b_bf != AW'(1)) ? tgt : pc1;
      OP_CMP: next_pc_o = equal ? pc2 : pc1;
      OP_SLT: next_pc_o = less ? pc2 : pc1;
      OP_SPL: split_o = 1'b1;
      default: begin
        kill_o    = 1'b1;
        next_pc_o = pc_i;
      end
    endcase
  end

  always_comb begin
    AST_KILL_SPLIT_EXCL: assert (!(kill_o && split_o)); // R3
  end
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int M  = 8000,
  parameter int AW = $clog2(M),
  localparam int CW = OPW + 2*MDW + 2*AW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [OPW-1:0] op_i,
  input  logic [MDW-1:0] a_mode_i,
  input  logic [AW-1:0]  a_field_i,
  input  logic [MDW-1:0] b_mode_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [AW-1:0]  a_addr_i,
  input  logic [AW-1:0]  b_addr_i,
  input  logic [CW-1:0]  a_cell_i,
  input  logic [CW-1:0]  b_cell_i,
  output logic           done_o,
  output logic [AW-1:0]  next_pc_o,
  output logic           kill_o,
  output logic           split_o,
  output logic [AW-1:0]  split_addr_o,
  output logic           wr_en_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic [CW-1:0]  wr_cell_o
);
  localparam int NNORM = 8;
  localparam int BF_LO = 0;
  localparam int BM_LO = AW;
  localparam int AF_LO = AW + MDW;
  localparam int AM_LO = 2*AW + MDW;
  localparam int OP_LO = 2*AW + 2*MDW;
  localparam logic [AW:0] M_W = (AW+1)'(M);

  logic [AW-1:0] raw [NNORM];
  logic [AW-1:0] nrm [NNORM];

  assign raw[0] = pc_i;
  assign raw[1] = a_addr_i;
  assign raw[2] = b_addr_i;
  assign raw[3] = a_field_i;
  assign raw[4] = a_cell_i[AF_LO +: AW];
  assign raw[5] = a_cell_i[BF_LO +: AW];
  assign raw[6] = b_cell_i[AF_LO +: AW];
  assign raw[7] = b_cell_i[BF_LO +: AW];

  for (genvar g = 0; g < NNORM; g++) begin : g_norm
    exu_norm #(.M(M), .AW(AW)) i_norm (.x_i(raw[g]), .y_o(nrm[g]));
  end

  logic [CW-1:0] a_cell_n, b_cell_n;
  assign a_cell_n = {a_cell_i[OP_LO +: OPW], a_cell_i[AM_LO +: MDW], nrm[4],
                     a_cell_i[BM_LO +: MDW], nrm[5]};
  assign b_cell_n = {b_cell_i[OP_LO +: OPW], b_cell_i[AM_LO +: MDW], nrm[6],
                     b_cell_i[BM_LO +: MDW], nrm[7]};

  logic a_imm, b_imm;
  assign a_imm = (a_mode_i == MODE_IMM);
  assign b_imm = (b_mode_i == MODE_IMM);

  logic          alu_wr_en;
  logic [CW-1:0] alu_cell;
  logic [AW-1:0] fl_next_pc, fl_split_addr;
  logic          fl_kill, fl_split;

  exu_alu #(.M(M), .AW(AW)) i_alu (
    .op_i      (op_i),
    .a_imm_i   (a_imm),
    .b_imm_i   (b_imm),
    .i_af_i    (nrm[3]),
    .a_cell_i  (a_cell_n),
    .b_cell_i  (b_cell_n),
    .wr_en_o   (alu_wr_en),
    .wr_cell_o (alu_cell)
  );

  exu_flow #(.M(M), .AW(AW)) i_flow (
    .op_i         (op_i),
    .a_imm_i      (a_imm),
    .b_imm_i      (b_imm),
    .i_af_i       (nrm[3]),
    .pc_i         (nrm[0]),
    .a_addr_i     (nrm[1]),
    .a_cell_i     (a_cell_n),
    .b_cell_i     (b_cell_n),
    .next_pc_o    (fl_next_pc),
    .kill_o       (fl_kill),
    .split_o      (fl_split),
    .split_addr_o (fl_split_addr)
  );

  logic ready_q, accept;
  assign accept     = in_valid_i & ready_q;
  assign in_ready_o = ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q      <= 1'b0;
      done_o       <= 1'b0;
      next_pc_o    <= '0;
      kill_o       <= 1'b0;
      split_o      <= 1'b0;
      split_addr_o <= '0;
      wr_en_o      <= 1'b0;
      wr_addr_o    <= '0;
      wr_cell_o    <= '0;
    end else begin
      ready_q <= 1'b1;
      done_o  <= accept;
      kill_o  <= accept & fl_kill;
      split_o <= accept & fl_split;
      wr_en_o <= accept & alu_wr_en;
      if (accept) begin
        next_pc_o    <= fl_next_pc;
        split_addr_o <= fl_split_addr;
        wr_addr_o    <= nrm[2];
        wr_cell_o    <= alu_cell;
      end
    end
  end

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> done_o); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !done_o); // R2
  AST_SIDE_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !kill_o && !split_o && !wr_en_o); // R2
  AST_KILL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_o |-> !wr_en_o && !split_o); // R3
  AST_PC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({1'b0, next_pc_o} < M_W) && ({1'b0, split_addr_o} < M_W)); // R11
  AST_WR_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ({1'b0, wr_addr_o} < M_W)); // R11
  AST_READY_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> in_ready_o); // R1
endmodule

// File: tb/test_exu_core.sv
`timescale 1ns/1ps
module test_exu_core;
  localparam int M  = 20;
  localparam int AW = 5;
  localparam int CW = 2*AW + 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [3:0] op = '0;
  logic [1:0] amode = '0, bmode = '0;
  logic [AW-1:0] afield = '0, pc = '0, aaddr = '0, baddr = '0;
  logic [CW-1:0] acell = '0, bcell = '0;
  logic done, kill, split, wr_en;
  logic [AW-1:0] next_pc, split_addr, wr_addr;
  logic [CW-1:0] wr_cell;

  always #4 clk = ~clk;

  exu_core #(.M(M), .AW(AW)) i_exu_core (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .a_mode_i(amode), .a_field_i(afield), .b_mode_i(bmode),
    .pc_i(pc), .a_addr_i(aaddr), .b_addr_i(baddr), .a_cell_i(acell), .b_cell_i(bcell),
    .done_o(done), .next_pc_o(next_pc), .kill_o(kill), .split_o(split),
    .split_addr_o(split_addr), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_cell_o(wr_cell)
  );

  int checks = 0, errors = 0;

  // expected result of the previously driven cycle
  bit e_done = 0, e_kill = 0, e_split = 0, e_wr = 0;
  int e_pc = 0, e_saddr = 0, e_waddr = 0;
  int e_wop = 0, e_wam = 0, e_waf = 0, e_wbm = 0, e_wbf = 0;
  string e_tag = "R2";

  function automatic int n(int x); return x % M; endfunction
  function automatic int fop(logic [CW-1:0] c); return int'(c[CW-1 -: 4]); endfunction
  function automatic int fam(logic [CW-1:0] c); return int'(c[2*AW+3 -: 2]); endfunction
  function automatic int faf(logic [CW-1:0] c); return int'(c[2*AW+1 -: AW]); endfunction
  function automatic int fbm(logic [CW-1:0] c); return int'(c[AW+1 -: 2]); endfunction
  function automatic int fbf(logic [CW-1:0] c); return int'(c[AW-1:0]); endfunction
  function automatic logic [CW-1:0] mk(int o, int am, int af, int bm, int bf);
    return {4'(o), 2'(am), AW'(af), 2'(bm), AW'(bf)};
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic compare();
    chk("R2", "done", int'(done), int'(e_done));
    if (e_done) begin
      chk(e_tag, "next_pc", int'(next_pc), e_pc);
      chk(e_tag, "kill", int'(kill), int'(e_kill));
      chk(e_tag, "split", int'(split), int'(e_split));
      chk(e_tag, "wr_en", int'(wr_en), int'(e_wr));
      if (e_split) chk(e_tag, "split_addr", int'(split_addr), e_saddr);
      if (e_wr) begin
        chk(e_tag, "wr_addr", int'(wr_addr), e_waddr);
        chk(e_tag, "wr_op", fop(wr_cell), e_wop);
        chk(e_tag, "wr_am", fam(wr_cell), e_wam);
        chk(e_tag, "wr_af", faf(wr_cell), e_waf);
        chk(e_tag, "wr_bm", fbm(wr_cell), e_wbm);
        chk(e_tag, "wr_bf", fbf(wr_cell), e_wbf);
        chk("R11", "wr_bf range", int'(fbf(wr_cell) < M), 1);
      end
      chk("R11", "next_pc range", int'(int'(next_pc) < M), 1);
    end else begin
      chk("R2", "idle side outputs", int'(kill | split | wr_en), 0);
    end
  endtask

  // reference model: sets the expectation for the next sample
  task automatic apply(bit v, int o, int am, int af, int bm, int p, int aa, int ba,
                       logic [CW-1:0] ac, logic [CW-1:0] bc);
    bit ai, bi, fm, eq;
    int ip, tgt, iaf, a_af, a_bf, b_af, b_bf, aval;
    in_valid = v; op = 4'(o); amode = 2'(am); bmode = 2'(bm); afield = AW'(af);
    pc = AW'(p); aaddr = AW'(aa); baddr = AW'(ba); acell = ac; bcell = bc;
    ai = (am == 0); bi = (bm == 0); fm = ai || bi;
    ip = n(p); iaf = n(af);
    a_af = n(faf(ac)); a_bf = n(fbf(ac)); b_af = n(faf(bc)); b_bf = n(fbf(bc));
    tgt = ai ? ip : n(aa);
    aval = ai ? iaf : a_bf;
    e_done = v; e_kill = 0; e_split = 0; e_wr = 0;
    e_pc = (ip + 1) % M; e_saddr = 0; e_waddr = n(ba);
    e_wop = fop(bc); e_wam = fam(bc); e_waf = b_af; e_wbm = fbm(bc); e_wbf = b_bf;
    case (o)
      1: begin
        e_tag = "R4"; e_wr = 1;
        if (fm) e_wbf = aval;
        else begin e_wop = fop(ac); e_wam = fam(ac); e_waf = a_af; e_wbm = fbm(ac); e_wbf = a_bf; end
      end
      2, 3: begin
        e_tag = "R5"; e_wr = 1;
        if (ai) e_wbf = (o == 2) ? (b_bf + iaf) % M : (b_bf - iaf + M) % M;
        else if (o == 2) begin e_waf = (b_af + a_af) % M; e_wbf = (b_bf + a_bf) % M; end
        else begin e_waf = (b_af - a_af + M) % M; e_wbf = (b_bf - a_bf + M) % M; end
      end
      4: begin e_tag = "R10"; e_pc = tgt; end
      5: begin e_tag = "R6"; if (b_bf == 0) e_pc = tgt; end
      6: begin e_tag = "R6"; if (b_bf != 0) e_pc = tgt; end
      7: begin
        e_tag = "R7"; e_wr = 1; e_wbf = (b_bf + M - 1) % M;
        if (e_wbf != 0) e_pc = tgt;
      end
      8: begin
        e_tag = "R8";
        if (fm) eq = (aval == b_bf);
        else eq = fop(ac) == fop(bc) && fam(ac) == fam(bc) && a_af == b_af &&
                  fbm(ac) == fbm(bc) && a_bf == b_bf;
        if (eq) e_pc = (ip + 2) % M;
      end
      9: begin e_tag = "R10"; e_split = 1; e_saddr = tgt; end
      10: begin e_tag = "R9"; if (aval < b_bf) e_pc = (ip + 2) % M; end
      default: begin e_tag = "R3"; e_kill = 1; e_pc = ip; end
    endcase
  endtask

  task automatic step(bit v, int o, int am, int af, int bm, int p, int aa, int ba,
                      logic [CW-1:0] ac, logic [CW-1:0] bc);
    @(negedge clk);
    compare();
    apply(v, o, am, af, bm, p, aa, ba, ac, bc);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk("R1", "reset done", int'(done), 0);
    chk("R1", "reset side", int'(kill | split | wr_en), 0);
    chk("R1", "reset ready", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", int'(in_ready), 1);

    // R4 move: immediate A field copy, whole cell copy, immediate B uses A cell B-field
    step(1, 1, 0, 7, 1, 3, 5, 9, mk(2,1,4,1,6), mk(5,2,11,3,12));
    step(1, 1, 1, 7, 2, 3, 5, 9, mk(2,1,4,1,6), mk(5,2,11,3,12));
    step(1, 1, 2, 7, 0, 3, 5, 9, mk(2,1,4,1,6), mk(5,2,11,3,12));
    // R5 add/sub immediate and pairwise, with wrap
    step(1, 2, 0, 15, 1, 0, 1, 2, mk(0,0,9,0,9), mk(1,1,10,1,8));
    step(1, 2, 1, 15, 1, 0, 1, 2, mk(0,0,13,0,17), mk(1,1,10,1,8));
    step(1, 3, 1, 0, 1, 0, 1, 2, mk(0,0,13,0,17), mk(1,1,10,1,8));
    step(1, 3, 0, 4, 1, 0, 1, 2, mk(0,0,13,0,17), mk(1,1,10,1,3));
    step(0, 0, 0, 0, 0, 0, 0, 0, '0, '0);
    // R6 jump on zero / nonzero
    step(1, 5, 1, 0, 1, 6, 11, 2, '0, mk(0,0,0,0,0));
    step(1, 5, 1, 0, 1, 6, 11, 2, '0, mk(0,0,0,0,4));
    step(1, 6, 1, 0, 1, 6, 11, 2, '0, mk(0,0,0,0,4));
    step(1, 6, 0, 0, 1, 6, 11, 2, '0, mk(0,0,0,0,0));
    // R7 decrement: 1 -> 0 no branch, 0 -> M-1 branch
    step(1, 7, 1, 0, 1, 6, 11, 2, '0, mk(0,0,3,0,1));
    step(1, 7, 1, 0, 1, 6, 11, 2, '0, mk(0,0,3,0,0));
    // R8 compare field and whole cells
    step(1, 8, 0, 8, 1, 18, 0, 0, '0, mk(3,1,2,1,8));
    step(1, 8, 1, 0, 1, 18, 0, 0, mk(3,1,2,1,8), mk(3,1,2,1,8));
    step(1, 8, 1, 0, 1, 18, 0, 0, mk(3,1,2,2,8), mk(3,1,2,1,8));
    // R9 skip if less
    step(1, 10, 0, 3, 1, 5, 0, 0, '0, mk(0,0,0,0,4));
    step(1, 10, 0, 4, 1, 5, 0, 0, '0, mk(0,0,0,0,4));
    // R10 jump and split, immediate target is the PC
    step(1, 4, 1, 0, 1, 5, 13, 0, '0, '0);
    step(1, 4, 0, 0, 1, 5, 13, 0, '0, '0);
    step(1, 9, 2, 0, 1, 5, 13, 0, '0, '0);
    step(1, 9, 0, 0, 1, 5, 13, 0, '0, '0);
    // R3 data and unused opcodes kill
    step(1, 0, 1, 0, 3, 7, 1, 1, '0, '0);
    step(1, 13, 1, 0, 1, 7, 1, 1, '0, '0);
    // R11 wrap of PC and unnormalised inputs
    step(1, 1, 0, 0, 1, M-1, 0, 0, '0, '0);
    step(1, 8, 0, 2, 1, M-1, 0, 0, '0, mk(0,0,0,0,2));
    step(1, 4, 1, 0, 1, 3, M+5, 0, '0, '0);
    step(1, 2, 1, 0, 1, M+2, 0, M+3, mk(0,0,M+1,0,M+4), mk(0,0,M+9,0,M+11));

    for (int i = 0; i < 600; i++) begin
      logic [CW-1:0] ac, bc;
      ac = CW'($urandom);
      bc = ($urandom % 4 == 0) ? ac : CW'($urandom);
      step(($urandom % 4) != 0, int'($urandom % 16), int'($urandom % 4), int'($urandom % 32),
           int'($urandom % 4), int'($urandom % 32), int'($urandom % 32), int'($urandom % 32), ac, bc);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, '0, '0);
    step(0, 0, 0, 0, 0, 0, 0, 0, '0, '0);
    finish_sim();
  end
endmodule